// File: doc/BRIEF.md
# Clocked Serial Transmit/Receive Engine with Inter-Frame Gap

This block moves 8-bit frames over a three-wire clocked serial link: a data line out, a data line in, and a shift clock. In internal-clock mode it makes the shift clock by dividing the system clock. In external-clock mode it follows a clock supplied from outside. A two-entry transmit buffer lets software queue the next byte while the current one is being shifted. Between buffered frames sent back to back, a programmable idle gap of 0 to 64 shift-clock periods can be inserted.

A control word selects the transfer direction, which can be off, receive only, transmit only or full duplex. The same word enables transmission and chooses the clock source. It also decides whether the block keeps running or freezes while the chip-wide idle input is high. Received frames land in a holding register with a valid flag. An overrun flag records a frame that arrived before the previous one was read.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `sclk_out` and `sdo` are 1, `rx_valid` and `rx_overrun` are 0, `txbuf_empty` is 1 and `txbuf_full` is 0.
- R2: A frame is 8 bits, least significant bit first. In internal-clock mode `sclk_out` idles high and each half period lasts HALF_DIV system clocks. `sdo` changes only together with a falling edge of `sclk_out`, and `sdi` is sampled at each rising edge.
- R3: When frames are sent back to back from the buffer in internal-clock mode, `sclk_out` stays high for HALF_DIV*(1+2L) system clocks between the last rising edge of one frame and the first falling edge of the next. L is set by `gap_sel`: 0→0, 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64.
- R4: When the buffer is empty at the end of a frame, the shift clock stops and no gap is counted. In external-clock mode the gap setting has no effect and a buffered frame follows at once.
- R5: `xfer_mode` 00 starts no frame. 01 runs receive-only frames continuously with `sdo` held at 1. 10 transmits from the buffer and never raises `rx_valid`. 11 transmits and receives.
- R6: If `tx_en` is cleared during a frame, that frame completes in full and no further frame starts. The remaining buffered data is kept.
- R7: While `chip_idle` is 1 and `run_in_idle` is 0, the engine freezes: `sclk_out`, `sdo` and the frame position hold. With `run_in_idle` at 1, operation continues.
- R8: The transmit buffer holds two bytes and is sent in write order. A write while `txbuf_full` is 1 is discarded. `txbuf_full` and `txbuf_empty` are never both 1.
- R9: In modes 01 and 11, each completed frame loads `rx_data` (first bit received in bit 0) and sets `rx_valid`. A one-cycle `rx_read` pulse clears `rx_valid`.
- R10: When a frame completes while `rx_valid` is still 1, `rx_overrun` is set, and it stays set until `rx_read`.
- R11: With `ext_clk_sel` at 1, bits shift on edges of `sclk_in`, which pass through a two-flop synchroniser. `sclk_out` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| gap_sel | input | 3 | Inter-frame gap code |
| tx_en | input | 1 | Transmit enable |
| xfer_mode | input | 2 | Transfer direction select |
| run_in_idle | input | 1 | 1 = keep running while chip_idle is high |
| ext_clk_sel | input | 1 | 1 = shift on sclk_in, 0 = divided system clock |
| chip_idle | input | 1 | Chip-wide idle request |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Byte to queue |
| rx_read | input | 1 | Acknowledges the received byte |
| sdi | input | 1 | Serial data in |
| sclk_in | input | 1 | External shift clock |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated shift clock |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte not yet read |
| rx_overrun | output | 1 | A frame arrived while rx_valid was set |
| txbuf_full | output | 1 | Buffer holds two bytes |
| txbuf_empty | output | 1 | Buffer holds no bytes |

## Verification
The hardest states to reach from the ports are the ones in the middle of a frame: clearing `tx_en`, or raising `chip_idle`, after some bits are out but before the last rising edge. The bench counts `sclk_out` edges in a monitor and drives these controls only once a set number of falling edges has been seen. It then confirms that the edge count freezes, or that exactly one frame finishes. The gaps are measured as cycle distances between monitor-observed edges for every code, using random data bytes. The external-clock path is driven with a slow bench-made clock while the gap code is set to its largest value.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        gap_sel,
  input  logic              tx_en,
  input  logic [1:0]        xfer_mode,
  input  logic              run_in_idle,
  input  logic              ext_clk_sel,
  input  logic              chip_idle,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_read,
  input  logic              sdi,
  input  logic              sclk_in,
  output logic              sdo,
  output logic              sclk_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_overrun,
  output logic              txbuf_full,
  output logic              txbuf_empty
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int HC_W  = $clog2(2 * DATA_W);
  localparam int GAP_W = 8;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(2 * DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t            state, state_nx;
  logic [DIV_W-1:0]  divcnt;
  logic [HC_W-1:0]   hcnt;
  logic [GAP_W-1:0]  gcnt;
  logic [DATA_W-1:0] tsh, buf0, buf1;
  logic [DATA_W-2:0] rsh;
  logic [1:0]        bcnt;
  logic              sclk_r, sdo_r, e1, e2, e3;

  logic run, ext_rise, ext_fall, tick, step_ev, fall_ev, rise_ev, last_rise;
  logic can_tx, can_start, use_gap, gap_done, start, pop, push, cap;
  logic [GAP_W-1:0]  gap_ticks;
  logic [DATA_W-1:0] rsh_nx;

  assign run       = ~(chip_idle & ~run_in_idle);
  assign ext_rise  = e2 & ~e3;
  assign ext_fall  = ~e2 & e3;
  assign tick      = run & ~ext_clk_sel & (divcnt == DIV_LAST);
  assign step_ev   = ext_clk_sel ? (run & (hcnt[0] ? ext_rise : ext_fall)) : tick;
  assign fall_ev   = (state == S_SHIFT) & ~hcnt[0] & step_ev;
  assign rise_ev   = (state == S_SHIFT) & hcnt[0] & step_ev;
  assign last_rise = rise_ev & (hcnt == HC_LAST);

  assign can_tx    = xfer_mode[1] & tx_en & (bcnt != 2'd0);
  assign can_start = can_tx | (xfer_mode == 2'b01);
  assign gap_ticks = (gap_sel == 3'd0) ? '0 : (GAP_W'(2) << (gap_sel - 3'd1));
  assign use_gap   = ~ext_clk_sel & (gap_sel != 3'd0);
  assign gap_done  = (state == S_GAP) & tick & (gcnt == gap_ticks - 1'b1);

  always_comb begin
    start    = 1'b0;
    state_nx = state;
    case (state)
      S_IDLE:  if (run && can_start) start = 1'b1;
      S_SHIFT: if (last_rise) begin
                 if (can_tx && use_gap) state_nx = S_GAP;
                 else if (can_start)    start    = 1'b1;
                 else                   state_nx = S_IDLE;
               end
      S_GAP:   if (gap_done) begin
                 if (can_start) start    = 1'b1;
                 else           state_nx = S_IDLE;
               end
      default: state_nx = S_IDLE;
    endcase
    if (start) state_nx = S_SHIFT;
  end

  assign pop    = start & can_tx;
  assign push   = wr_en & (bcnt != 2'd2);
  assign cap    = last_rise & xfer_mode[0];
  assign rsh_nx = {sdi, rsh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      divcnt <= '0;
      gcnt   <= '0;
      hcnt   <= '0;
    end else begin
      state <= state_nx;
      if (run) divcnt <= (state == S_IDLE || ext_clk_sel || tick) ? '0 : divcnt + 1'b1;
      if (state != S_GAP) gcnt <= '0;
      else if (tick)      gcnt <= gcnt + 1'b1;
      if (start)                  hcnt <= '0;
      else if (fall_ev | rise_ev) hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh    <= '1;
      rsh    <= '0;
      sdo_r  <= 1'b1;
      sclk_r <= 1'b1;
    end else begin
      if (start)        tsh <= can_tx ? buf0 : '1;
      else if (fall_ev) tsh <= {1'b1, tsh[DATA_W-1:1]};
      if (fall_ev) sdo_r <= tsh[0];
      if (rise_ev) rsh <= rsh_nx[DATA_W-1:1];
      if (ext_clk_sel)  sclk_r <= 1'b1;
      else if (fall_ev) sclk_r <= 1'b0;
      else if (rise_ev) sclk_r <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (rx_read) begin
        rx_valid   <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (cap) begin
        rx_data  <= rsh_nx;
        rx_valid <= 1'b1;
        if (rx_valid && !rx_read) rx_overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf0 <= '0;
      buf1 <= '0;
      bcnt <= 2'd0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (bcnt == 2'd0) buf0 <= wr_data;
          else              buf1 <= wr_data;
          bcnt <= bcnt + 2'd1;
        end
        2'b01: begin
          buf0 <= buf1;
          bcnt <= bcnt - 2'd1;
        end
        2'b11: buf0 <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1 <= 1'b1;
      e2 <= 1'b1;
      e3 <= 1'b1;
    end else begin
      e1 <= sclk_in;
      e2 <= e1;
      e3 <= e2;
    end
  end

  assign sdo         = sdo_r;
  assign sclk_out    = sclk_r;
  assign txbuf_full  = (bcnt == 2'd2);
  assign txbuf_empty = (bcnt == 2'd0);
endmodule

// File: rtl/sync_serial_port_sva.sv
module sync_serial_port_sva (
  input logic clk,
  input logic rst_n,
  input logic chip_idle,
  input logic run_in_idle,
  input logic ext_clk_sel,
  input logic wr_en,
  input logic sdo,
  input logic sclk_out,
  input logic rx_valid,
  input logic rx_overrun,
  input logic txbuf_full,
  input logic txbuf_empty
);
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(txbuf_full && txbuf_empty));

  p_fill_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txbuf_empty) |-> $past(wr_en));

  p_halt_holds_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_idle && !run_in_idle && !ext_clk_sel) |=> $stable(sclk_out));

  p_halt_holds_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_idle && !run_in_idle) |=> $stable(sdo));

  p_ext_clk_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |=> sclk_out);

  p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && $past(!ext_clk_sel) && !$stable(sdo)) |-> !sclk_out);

  p_overrun_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid));
endmodule

bind sync_serial_port sync_serial_port_sva u_sva (
  .clk(clk), .rst_n(rst_n), .chip_idle(chip_idle), .run_in_idle(run_in_idle),
  .ext_clk_sel(ext_clk_sel), .wr_en(wr_en), .sdo(sdo), .sclk_out(sclk_out),
  .rx_valid(rx_valid), .rx_overrun(rx_overrun), .txbuf_full(txbuf_full),
  .txbuf_empty(txbuf_empty)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] gap_sel = 3'd0;
  logic tx_en = 1'b0, run_in_idle = 1'b0, ext_clk_sel = 1'b0, chip_idle = 1'b0;
  logic [1:0] xfer_mode = 2'b00;
  logic wr_en = 1'b0, rx_read = 1'b0, sclk_in = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic sdi, sdi_mon = 1'b0, sdi_ext = 1'b0, ext_tb = 1'b0;
  logic sdo, sclk_out, rx_valid, rx_overrun, txbuf_full, txbuf_empty;
  logic [7:0] rx_data;

  assign sdi = ext_tb ? sdi_ext : sdi_mon;

  sync_serial_port #(.DATA_W(8), .HALF_DIV(HALF)) u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .gap_sel(gap_sel), .tx_en(tx_en), .xfer_mode(xfer_mode),
    .run_in_idle(run_in_idle), .ext_clk_sel(ext_clk_sel), .chip_idle(chip_idle),
    .wr_en(wr_en), .wr_data(wr_data), .rx_read(rx_read), .sdi(sdi), .sclk_in(sclk_in),
    .sdo(sdo), .sclk_out(sclk_out), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_overrun(rx_overrun), .txbuf_full(txbuf_full), .txbuf_empty(txbuf_empty));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, falls = 0, rises = 0, nfr = 0, bitidx = 0, last_rise = 0;
  logic prev_sclk = 1'b1;
  logic [7:0] cur = 8'h00;
  logic [7:0] frames [256];
  logic [7:0] sdi_pat [256];
  int gaps [256];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (prev_sclk && !sclk_out) begin
        falls = falls + 1;
        if (bitidx == 0) gaps[nfr % 256] = cyc - last_rise;
        sdi_mon = sdi_pat[nfr % 256][bitidx];
      end
      if (!prev_sclk && sclk_out) begin
        rises = rises + 1;
        cur[bitidx] = sdo;
        if (bitidx == 7) begin
          frames[nfr % 256] = cur;
          nfr = nfr + 1;
          bitidx = 0;
          last_rise = cyc;
        end else bitidx = bitidx + 1;
      end
    end
    prev_sclk = sclk_out;
  end

  function automatic int exp_gap(input int g);
    return (g == 0) ? HALF : HALF * (1 + 2 * (1 << (g - 1)));
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] b);
    step(); wr_en = 1'b1; wr_data = b;
    step(); wr_en = 1'b0;
  endtask

  task automatic write_two(input logic [7:0] a, input logic [7:0] b);
    step(); wr_en = 1'b1; wr_data = a;
    step(); wr_data = b;
    step(); wr_en = 1'b0;
  endtask

  task automatic wait_nfr(input int target, input string req);
    int n = 0;
    while (nfr < target && n < 3000) begin step(); n++; end
    if (nfr < target) check({req, " frame timeout"}, nfr, target);
  endtask

  task automatic wait_falls(input int target, input string req);
    int n = 0;
    while (falls < target && n < 3000) begin step(); n++; end
    if (falls < target) check({req, " edge timeout"}, falls, target);
  endtask

  task automatic read_rx();
    step(); rx_read = 1'b1;
    step(); rx_read = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base, f0, r0;
    logic [7:0] a, b, c;
    logic s0, d0;
    logic [15:0] epat, got;
    void'($urandom(32'h1357));
    for (int i = 0; i < 256; i++) sdi_pat[i] = 8'($urandom);

    repeat (4) step();
    check("R1 sclk_out", sclk_out, 1);
    check("R1 sdo", sdo, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_overrun", rx_overrun, 0);
    check("R1 empty", txbuf_empty, 1);
    check("R1 full", txbuf_full, 0);
    rst_n = 1'b1;
    repeat (3) step();

    // R8 / R5: fill in mode 00, third write dropped, nothing moves
    tx_en = 1'b1;
    a = 8'hA5; b = 8'h3C; c = 8'hF0;
    step(); wr_en = 1'b1; wr_data = a;
    step(); wr_data = b;
    step(); wr_data = c;
    step(); wr_en = 1'b0;
    check("R8 full after two", txbuf_full, 1);
    check("R8 not empty", txbuf_empty, 0);
    f0 = falls;
    repeat (60) step();
    check("R5 mode 00 no clock", falls, f0);
    base = nfr;
    xfer_mode = 2'b10;
    wait_nfr(base + 2, "R8");
    repeat (80) step();
    check("R8 only two frames", nfr, base + 2);
    check("R8 first byte", frames[base % 256], a);
    check("R8 second byte", frames[(base + 1) % 256], b);
    check("R8 empty after drain", txbuf_empty, 1);
    check("R3 zero gap", gaps[(base + 1) % 256], exp_gap(0));
    check("R5 mode 10 no rx", rx_valid, 0);

    // R3 / R4: every gap code with random data
    for (int g = 0; g < 8; g++) begin
      gap_sel = 3'(g);
      a = 8'($urandom); b = 8'($urandom);
      base = nfr;
      write_two(a, b);
      wait_nfr(base + 2, "R3");
      check("R3 byte a", frames[base % 256], a);
      check("R3 byte b", frames[(base + 1) % 256], b);
      check("R3 gap length", gaps[(base + 1) % 256], exp_gap(g));
      f0 = falls;
      repeat (60) step();
      check("R4 clock stops when empty", falls, f0);
    end

    // R9: full duplex, random gap codes
    xfer_mode = 2'b11;
    for (int k = 0; k < 6; k++) begin
      gap_sel = 3'($urandom);
      a = 8'($urandom);
      base = nfr;
      write_byte(a);
      wait_nfr(base + 1, "R9");
      check("R9 tx byte", frames[base % 256], a);
      check("R9 rx data", rx_data, sdi_pat[base % 256]);
      check("R9 rx valid", rx_valid, 1);
      read_rx();
      check("R9 read clears valid", rx_valid, 0);
    end

    // R10: two frames without reading
    gap_sel = 3'd0;
    base = nfr;
    write_two(8'h11, 8'h22);
    wait_nfr(base + 2, "R10");
    check("R10 overrun set", rx_overrun, 1);
    check("R10 rx holds latest", rx_data, sdi_pat[(base + 1) % 256]);
    read_rx();
    check("R10 read clears overrun", rx_overrun, 0);
    check("R10 read clears valid", rx_valid, 0);

    // R5: receive-only runs continuously with sdo high
    base = nfr;
    xfer_mode = 2'b01;
    wait_nfr(base + 2, "R5");
    xfer_mode = 2'b00;
    wait_nfr(base + 3, "R5");
    repeat (40) step();
    check("R5 rx-only stops in mode 00", nfr, base + 3);
    check("R5 sdo high frame 0", frames[base % 256], 8'hFF);
    check("R5 sdo high frame 1", frames[(base + 1) % 256], 8'hFF);
    check("R5 rx data", rx_data, sdi_pat[(base + 1) % 256]);
    check("R5 overrun in rx-only", rx_overrun, 1);
    read_rx();

    // R6: clear tx_en mid-frame
    xfer_mode = 2'b10;
    a = 8'($urandom); b = 8'($urandom);
    base = nfr; f0 = falls;
    write_two(a, b);
    wait_falls(f0 + 3, "R6");
    tx_en = 1'b0;
    wait_nfr(base + 1, "R6");
    repeat (80) step();
    check("R6 single frame", nfr, base + 1);
    check("R6 frame complete", frames[base % 256], a);
    check("R6 buffer kept", txbuf_empty, 0);
    tx_en = 1'b1;
    wait_nfr(base + 2, "R6");
    check("R6 resumed byte", frames[(base + 1) % 256], b);
    step();
    check("R6 drained", txbuf_empty, 1);

    // R7: halt and run-in-idle
    run_in_idle = 1'b0;
    a = 8'($urandom);
    base = nfr; f0 = falls;
    write_byte(a);
    wait_falls(f0 + 3, "R7");
    chip_idle = 1'b1;
    f0 = falls; r0 = rises; s0 = sclk_out; d0 = sdo;
    repeat (40) step();
    check("R7 falls frozen", falls, f0);
    check("R7 rises frozen", rises, r0);
    check("R7 sclk held", sclk_out, s0);
    check("R7 sdo held", sdo, d0);
    chip_idle = 1'b0;
    wait_nfr(base + 1, "R7");
    check("R7 frame after halt", frames[base % 256], a);
    run_in_idle = 1'b1; chip_idle = 1'b1;
    a = 8'($urandom);
    base = nfr;
    write_byte(a);
    wait_nfr(base + 1, "R7");
    check("R7 runs in idle", frames[base % 256], a);
    chip_idle = 1'b0;

    // R11 / R4: external clock, gap code ignored
    xfer_mode = 2'b11;
    gap_sel = 3'd7;
    step(); ext_clk_sel = 1'b1; ext_tb = 1'b1;
    repeat (4) step();
    a = 8'($urandom); b = 8'($urandom); epat = 16'($urandom);
    write_byte(a);
    write_byte(b);
    repeat (6) step();
    f0 = falls;
    got = '0;
    for (int i = 0; i < 16; i++) begin
      sclk_in = 1'b0; sdi_ext = epat[i];
      repeat (8) step();
      got[i] = sdo;
      sclk_in = 1'b1;
      repeat (8) step();
    end
    check("R11 ext byte a", got[7:0], a);
    check("R4 ext no gap byte b", got[15:8], b);
    check("R11 sclk_out held high", falls, f0);
    check("R11 ext rx data", rx_data, epat[15:8]);
    check("R11 ext overrun", rx_overrun, 1);
    check("R11 buffer drained", txbuf_empty, 1);

    summary();
    $finish;
  end
endmodule